// File: doc/BRIEF.md
# Two-Wire Slave Register Access Controller

This block is the serial front end of a small mixed-signal controller. It watches a two-wire bus and finds start and stop conditions. It shifts in address and data bytes and pulls SDA low to acknowledge the bytes it accepts. The first byte of every transfer must carry the device type. Three bits of that byte pick a space: the potentiometer space or the control register. The lowest bit chooses between read and write.

A write to the control register is built from three bytes: the slave address, a register address of FFh and exactly one data byte. The data byte takes effect only when the master sends STOP. Two volatile latches guard every persistent write, and they are set by two separate unlock transfers. When a persistent write is accepted, the block emits a register-write strobe with the data and a pulse that starts the nonvolatile store. It then stays busy for a fixed number of cycles. While busy it refuses every slave address, so the master can poll for the end of the store.

Top module: `tw_slave_top`

## Requirements
- R1: The slave address byte is acknowledged only when its bits 7:4 equal 1010. Any other value is not acknowledged, and the rest of that transfer is ignored.
- R2: Slave address bits 3:1 equal to 010 select the control register, and the address is acknowledged for both read (bit 0 = 1) and write (bit 0 = 0). Codes other than 010 and 111 are reserved and are not acknowledged.
- R3: Code 111 selects the potentiometer space. A read is always acknowledged. A write is acknowledged only while the write-enable latch is set. `potActive` is high from an accepted potentiometer address until the next STOP.
- R4: After a control register write address, the next byte is acknowledged only when it equals FFh. Any other value is not acknowledged, and no later byte in that transfer is acknowledged or used.
- R5: The first data byte of a control register write is acknowledged. Every later data byte in the same transfer is not acknowledged.
- R6: On STOP, data 02h sets the write-enable latch (`welOut`). Data 06h sets the second latch (`rwelOut`) only when the write-enable latch is already set. Neither value produces a strobe or a commit.
- R7: On STOP, a data byte with bit 4 = 1 is ignored: no strobe, no commit, and no latch change.
- R8: On STOP, any other data byte is accepted only when both latches are set. It then produces exactly one pulse on `regWrStb` and `nvCommit`, in the same cycle, with the byte on `regWrData`.
- R9: A data byte that is neither 02h nor 06h and arrives while either latch is clear produces no strobe and no commit.
- R10: A STOP before all eight data bits have arrived causes no strobe, no commit and no latch change.
- R11: `busy` is high for exactly BUSY_CYCLES clock cycles, starting with the commit cycle. While it is high, every slave address is not acknowledged.
- R12: SDA is pulled low only during the acknowledge bit of an accepted byte. The pull starts after the eighth falling SCL edge and is released at the next falling edge.
- R13: After reset, both latches are clear, and `busy`, `potActive`, `regWrStb`, `nvCommit`, `regWrData` and `sdaPullLow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaPullLow | output | 1 | When high, the SDA driver pulls the line low (acknowledge) |
| potActive | output | 1 | Potentiometer space addressed in the current transfer |
| regWrStb | output | 1 | One-cycle persistent register write strobe |
| regWrData | output | 8 | Data of the last accepted persistent write |
| nvCommit | output | 1 | One-cycle pulse that starts the nonvolatile store |
| welOut | output | 1 | Write-enable latch |
| rwelOut | output | 1 | Register write-enable latch |
| busy | output | 1 | Nonvolatile store in progress |

## Verification
The acknowledge bit is due in the ninth SCL low phase. It appears a few clocks after the synchronised falling edge, so the bench samples SDA in the middle of the following high phase, well clear of both edges. The strobe and commit pulse are due three to four clocks after SDA rises for the STOP. A monitor pops the expected byte from a queue whenever the pulse appears, and the driver requires that queue to be empty twenty cycles after each STOP. Latch outputs are read only after that settling window. The busy window is counted exactly by the monitor, from the commit cycle up to the first cycle in which `busy` is low.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam logic [3:0] DEV_TYPE  = 4'b1010;
  localparam logic [2:0] SPACE_POT = 3'b111;
  localparam logic [2:0] SPACE_CSR = 3'b010;
  localparam logic [7:0] REG_ADDR  = 8'hFF;
  localparam logic [7:0] UNLOCK_A  = 8'h02;
  localparam logic [7:0] UNLOCK_B  = 8'h06;
  localparam int         RSVD_BIT  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_REG, ST_DATA, ST_EXTRA, ST_SKIP
  } twState_t;

  // control -> datapath
  typedef struct packed {
    logic ackArm;
    logic busClear;
  } ctlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic       start;
    logic       stop;
    logic       byteDone;
    logic [7:0] rxByte;
  } busEvt_t;
endpackage

// File: rtl/tw_bitpath.sv
module tw_bitpath import tw_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  ctlStrobes_t strb,
  output busEvt_t     evt,
  output logic        sdaPullLow
);
  localparam int FRAME_BITS = 9;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall;
  logic [CNT_W-1:0] bitCnt;
  logic [6:0] shiftReg;
  logic ackArmed, inAck;

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;

  assign evt.start    = sclS & sclPrev & ~sdaS & sdaPrev;
  assign evt.stop     = sclS & sclPrev & sdaS & ~sdaPrev;
  assign evt.byteDone = sclRise && (bitCnt == CNT_W'(7));
  assign evt.rxByte   = {shiftReg, sdaS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (evt.start) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (sclRise) begin
      shiftReg <= {shiftReg[5:0], sdaS};
      bitCnt   <= (bitCnt == CNT_W'(FRAME_BITS-1)) ? '0 : bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackArmed   <= 1'b0;
      inAck      <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (strb.busClear) begin
      ackArmed   <= 1'b0;
      inAck      <= 1'b0;
      sdaPullLow <= 1'b0;
    end else begin
      if (strb.ackArm) ackArmed <= 1'b1;
      if (sclFall) begin
        if (ackArmed) begin
          sdaPullLow <= 1'b1;
          inAck      <= 1'b1;
          ackArmed   <= 1'b0;
        end else if (inAck) begin
          sdaPullLow <= 1'b0;
          inAck      <= 1'b0;
        end
      end
    end
  end

  // R12: the acknowledge pull may only begin while the clock is low
  p_ack_rise_scl_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclS);
  // R12: release happens on a low clock or on a bus condition
  p_ack_fall_scl_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> (!sclS || $past(strb.busClear)));
endmodule

// File: rtl/tw_regctl.sv
module tw_regctl import tw_pkg::*; #(
  parameter int BUSY_CYCLES = 400
) (
  input  logic        clk,
  input  logic        rstN,
  input  busEvt_t     evt,
  output ctlStrobes_t strb,
  output logic        potActive,
  output logic        regWrStb,
  output logic [7:0]  regWrData,
  output logic        nvCommit,
  output logic        wel,
  output logic        rwel,
  output logic        busy
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  twState_t st;
  logic [BUSY_W-1:0] busyCnt;
  logic [7:0] dataReg;
  logic [7:0] rx;

  assign rx   = evt.rxByte;
  assign busy = (busyCnt != '0);

  always_comb begin
    strb.ackArm   = 1'b0;
    strb.busClear = evt.start | evt.stop;
    if (evt.byteDone) begin
      unique case (st)
        ST_DEV: if (!busy && rx[7:4] == DEV_TYPE) begin
          if (rx[3:1] == SPACE_CSR)      strb.ackArm = 1'b1;
          else if (rx[3:1] == SPACE_POT) strb.ackArm = rx[0] | wel;
        end
        ST_REG:  strb.ackArm = (rx == REG_ADDR);
        ST_DATA: strb.ackArm = 1'b1;
        default: strb.ackArm = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      potActive <= 1'b0;
      regWrStb  <= 1'b0;
      nvCommit  <= 1'b0;
      regWrData <= '0;
      wel       <= 1'b0;
      rwel      <= 1'b0;
      busyCnt   <= '0;
      dataReg   <= '0;
    end else begin
      regWrStb <= 1'b0;
      nvCommit <= 1'b0;
      if (busy) busyCnt <= busyCnt - 1'b1;
      if (evt.start) begin
        st        <= ST_DEV;
        potActive <= 1'b0;
      end else if (evt.stop) begin
        st        <= ST_IDLE;
        potActive <= 1'b0;
        if (st == ST_EXTRA && !dataReg[RSVD_BIT]) begin
          if (dataReg == UNLOCK_A) wel <= 1'b1;
          else if (dataReg == UNLOCK_B) begin
            if (wel) rwel <= 1'b1;
          end else if (wel && rwel) begin
            regWrStb  <= 1'b1;
            nvCommit  <= 1'b1;
            regWrData <= dataReg;
            busyCnt   <= BUSY_W'(BUSY_CYCLES);
          end
        end
      end else if (evt.byteDone) begin
        unique case (st)
          ST_DEV: if (strb.ackArm) begin
            st        <= (rx[3:1] == SPACE_CSR && !rx[0]) ? ST_REG : ST_SKIP;
            potActive <= (rx[3:1] == SPACE_POT);
          end else st <= ST_SKIP;
          ST_REG:  st <= strb.ackArm ? ST_DATA : ST_SKIP;
          ST_DATA: begin
            dataReg <= rx;
            st      <= ST_EXTRA;
          end
          default: st <= st;
        endcase
      end
    end
  end

  p_rwel_needs_wel_r6: assert property (@(posedge clk) disable iff (!rstN)
    rwel |-> wel);
  p_commit_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    nvCommit |-> (wel && rwel && regWrStb));
  p_busy_on_commit_r11: assert property (@(posedge clk) disable iff (!rstN)
    nvCommit |-> busy);
  p_no_ack_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (evt.byteDone && st == ST_DEV && busy) |-> !strb.ackArm);
  p_single_data_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    (evt.byteDone && st == ST_EXTRA) |-> !strb.ackArm);
endmodule

// File: rtl/tw_slave_top.sv
module tw_slave_top import tw_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  output logic       potActive,
  output logic       regWrStb,
  output logic [7:0] regWrData,
  output logic       nvCommit,
  output logic       welOut,
  output logic       rwelOut,
  output logic       busy
);
  ctlStrobes_t strb;
  busEvt_t     evt;

  tw_bitpath #(.SYNC_STAGES(SYNC_STAGES)) i_bitpath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strb(strb), .evt(evt), .sdaPullLow(sdaPullLow)
  );

  tw_regctl #(.BUSY_CYCLES(BUSY_CYCLES)) i_regctl (
    .clk(clk), .rstN(rstN), .evt(evt), .strb(strb),
    .potActive(potActive), .regWrStb(regWrStb), .regWrData(regWrData),
    .nvCommit(nvCommit), .wel(welOut), .rwel(rwelOut), .busy(busy)
  );
endmodule

// File: tb/test_tw_slave_top.sv
module test_tw_slave_top;
  localparam int BUSY = 400;

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1;
  logic sdaLine;
  logic sdaPullLow, potActive, regWrStb, nvCommit, welOut, rwelOut, busy;
  logic [7:0] regWrData;
  int checks = 0, fails = 0;
  logic [7:0] expQ[$];
  int busyCount = 0;
  bit busyRun = 0;

  always #5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullLow;

  tw_slave_top #(.SYNC_STAGES(2), .BUSY_CYCLES(BUSY)) i_tw_slave_top (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .potActive(potActive), .regWrStb(regWrStb),
    .regWrData(regWrData), .nvCommit(nvCommit), .welOut(welOut),
    .rwelOut(rwelOut), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sclM = 1'b0; waitN(5); sdaM = 1'b1; waitN(5);
    sclM = 1'b1; waitN(10); sdaM = 1'b0; waitN(10);
  endtask

  task automatic busStop();
    sclM = 1'b0; waitN(5); sdaM = 1'b0; waitN(5);
    sclM = 1'b1; waitN(10); sdaM = 1'b1; waitN(20);
  endtask

  task automatic bitOut(input logic b);
    sclM = 1'b0; waitN(5); sdaM = b; waitN(5);
    sclM = 1'b1; waitN(10);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string tag);
    logic ack;
    for (int i = 7; i >= 0; i--) bitOut(b[i]);
    sclM = 1'b0; waitN(5); sdaM = 1'b1; waitN(5);
    sclM = 1'b1; waitN(5);
    ack = ~sdaLine;
    chk(tag, ack, expAck);
    waitN(5);
  endtask

  task automatic csrWrite(input logic [7:0] d, input string tag);
    busStart();
    sendByte(8'hA4, 1'b1, {tag, " R2 csr address"});
    sendByte(8'hFF, 1'b1, {tag, " R4 register byte"});
    sendByte(d, 1'b1, {tag, " R5 first data"});
    busStop();
    chk({tag, " R8 commit queue drained"}, expQ.size(), 0);
  endtask

  // monitor: scoreboard for strobes and busy window
  always @(negedge clk) begin
    if (rstN) begin
      if (regWrStb || nvCommit) begin
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL R8 unexpected commit actual=%0h expected=none", regWrData);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          chk("R8 strobe data", regWrData, e);
          chk("R8 strobe and commit together", {regWrStb, nvCommit}, 2'b11);
        end
        busyRun = 1; busyCount = 0;
      end
      if (busyRun) begin
        if (busy) busyCount++;
        else begin
          chk("R11 busy window length", busyCount, BUSY);
          busyRun = 0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    waitN(5); rstN = 1'b1; waitN(5);
    chk("R13 reset outputs",
        {welOut, rwelOut, busy, potActive, regWrStb, nvCommit, sdaPullLow, regWrData},
        15'h0);

    busStart(); sendByte(8'hB4, 1'b0, "R1 wrong device type");
    sendByte(8'hFF, 1'b0, "R1 rest ignored"); busStop();
    busStart(); sendByte(8'hA6, 1'b0, "R2 reserved code"); busStop();
    busStart(); sendByte(8'hA5, 1'b1, "R2 csr read"); busStop();
    busStart(); sendByte(8'hAE, 1'b0, "R3 pot write locked"); busStop();
    busStart(); sendByte(8'hAF, 1'b1, "R3 pot read");
    chk("R3 potActive on read", potActive, 1'b1); busStop();

    csrWrite(8'h23, "R9 locked data");
    chk("R9 latches stay clear", {welOut, rwelOut}, 2'b00);
    csrWrite(8'h06, "R6 06h before 02h");
    chk("R6 06h needs WEL", {welOut, rwelOut}, 2'b00);

    busStart(); sendByte(8'hA4, 1'b1, "R4 address");
    sendByte(8'hFE, 1'b0, "R4 bad register byte");
    sendByte(8'h02, 1'b0, "R4 data ignored"); busStop();
    chk("R4 no latch change", {welOut, rwelOut}, 2'b00);

    csrWrite(8'h02, "R6 unlock A");
    chk("R6 WEL set", {welOut, rwelOut}, 2'b10);

    busStart(); sendByte(8'hAE, 1'b1, "R3 pot write unlocked");
    chk("R3 potActive high", potActive, 1'b1); busStop();
    chk("R3 potActive low after stop", potActive, 1'b0);
    chk("R12 bus released", sdaPullLow, 1'b0);

    csrWrite(8'h06, "R6 unlock B");
    chk("R6 both latches", {welOut, rwelOut}, 2'b11);

    csrWrite(8'h35, "R7 reserved bit");
    chk("R7 no data change", regWrData, 8'h00);

    busStart(); sendByte(8'hA4, 1'b1, "R10 address");
    sendByte(8'hFF, 1'b1, "R10 register byte");
    for (int i = 0; i < 4; i++) bitOut(1'b0);
    busStop();
    chk("R10 no commit", {regWrData, busy}, 9'h000);

    busStart(); sendByte(8'hA4, 1'b1, "R5 address");
    sendByte(8'hFF, 1'b1, "R5 register byte");
    sendByte(8'h2B, 1'b1, "R5 first data acked");
    sendByte(8'h11, 1'b0, "R5 second data refused");
    sendByte(8'h22, 1'b0, "R5 third data refused");
    expQ.push_back(8'h2B);
    busStop();
    chk("R8 single commit drained", expQ.size(), 0);
    chk("R11 busy after commit", busy, 1'b1);

    busStart(); sendByte(8'hA4, 1'b0, "R11 address refused while busy"); busStop();
    while (busy) waitN(1);
    waitN(2);

    expQ.push_back(8'h00);
    csrWrite(8'h00, "R8 second commit after busy");
    while (busy) waitN(1);
    waitN(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule